// File: doc/BRIEF.md
# Pipeline Activity Idle Detector

This block tells a pipelined processor whether it still has work outstanding, so that the processor can decide when it may stop. Every time a stage sends something across an inter-stage buffer, the stage raises a one-cycle activity pulse. The block records that pulse as a one-bit mark in a short history register. The history register is as long as the slowest inter-stage path and shifts forward whenever the pipeline advances. The block also keeps one "busy" flag per stage, which the stages switch on and off through an index-addressed request port.

A single saturating counter holds the number of marks still in the history plus the number of busy stages. The `active` output is high whenever that counter is nonzero. When `active` is low, nothing is in flight and no stage has pending work, so the processor may idle. Software-free control is limited to a synchronous clear and a preload. Loading a large value into the counter through the preload keeps `active` high and so effectively disables idling.

Top module: `pipe_idle_detect`

## Requirements
- R1: After reset or a cycle with `clear` high, `count` is 0, `active` is 0, every history slot is empty and every stage flag is off. A later deactivate request therefore changes nothing, and a later activate request brings `count` to 1.
- R2: An `act_pulse` while slot 0 of the history is empty (and no `advance`) sets slot 0 and raises `count` by one. An `act_pulse` while slot 0 is already set leaves `count` unchanged.
- R3: Each `advance` shifts the history by one slot toward the oldest slot, which is slot LATENCY-1. A mark leaves the register on the LATENCY-th advance after it was set, and `count` drops by one in that cycle.
- R4: When `advance` and `act_pulse` arrive in the same cycle, the shift happens first and the new mark lands in the vacated slot 0. `count` takes the net change of the leaving mark and the new mark in that one cycle.
- R5: A request with `stage_req`=1 and `stage_set`=1 turns on the flag of stage `stage_idx` and raises `count` by one. A request with `stage_set`=0 turns the flag off and lowers `count` by one.
- R6: An activate request for a stage that is already on has no effect. A deactivate request for a stage that is already off also has no effect.
- R7: `active` is 1 exactly when `count` is nonzero, and both update at the same clock edge.
- R8: `preload_en` loads `preload_val` into `count` and overrides every other counter change in that cycle. `clear` overrides `preload_en`.
- R9: `count` saturates. It stays at 0 rather than wrapping below zero, and it stays at 2^CNT_W-1 rather than wrapping above it.
- R10: With no preload since the last clear, `count` equals the number of set history slots plus the number of active stages in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of history, flags and counter |
| act_pulse | input | 1 | A stage wrote an inter-stage buffer this cycle |
| advance | input | 1 | Pipeline buffers shift this cycle |
| stage_req | input | 1 | Stage flag request valid |
| stage_set | input | 1 | 1 = activate, 0 = deactivate |
| stage_idx | input | IDX_W | Stage addressed by the request |
| preload_en | input | 1 | Load the counter |
| preload_val | input | CNT_W | Value to load |
| count | output | CNT_W | Outstanding activity count (registered) |
| active | output | 1 | Counter nonzero (registered) |

## Verification
The hardest case to reach from the ports is a cycle where several counter effects overlap. One example is a mark leaving the oldest slot while a new mark enters slot 0. Another is a stage request arriving together with a pulse. The stimulus table places a single mark in the history and then counts exact advances so that the mark's exit lines up with a fresh pulse. The directed tests then cover duplicate requests, floor and ceiling saturation reached through preload, and clear colliding with preload.

// File: rtl/pid_pkg.sv
package pid_pkg;

  function automatic logic [15:0] sat_step(input logic [15:0] cur,
                                           input logic [1:0]  up,
                                           input logic [1:0]  down,
                                           input logic [15:0] maxv);
    logic [17:0] sum;
    logic [17:0] diff;
    sum = {2'b00, cur} + {16'd0, up};
    if (sum < {16'd0, down}) begin
      return 16'd0;
    end
    diff = sum - {16'd0, down};
    if (diff > {2'b00, maxv}) begin
      return maxv;
    end
    return diff[15:0];
  endfunction

endpackage

// File: rtl/pid_history.sv
module pid_history #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic act_pulse,
  input  logic advance,
  output logic mark_add,
  output logic mark_drop
);

  logic [LATENCY-1:0] hist;

  always_comb begin
    mark_drop = advance & hist[LATENCY-1];
    mark_add  = act_pulse & (advance | ~hist[0]);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hist <= '0;
    end else begin
      if (advance) begin
        hist <= {hist[LATENCY-2:0], act_pulse};
      end else if (act_pulse) begin
        hist[0] <= 1'b1;
      end
    end
  end

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> hist[LATENCY-1:1] == $past(hist[LATENCY-2:0])); // R3

  AST_SLOT0_MARK: assert property (@(posedge clk) disable iff (rst)
    (act_pulse && !clear) |=> hist[0]); // R2

endmodule

// File: rtl/pid_stage_flags.sv
module pid_stage_flags #(
  parameter int NUM_STAGES = 4,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             stage_req,
  input  logic             stage_set,
  input  logic [IDX_W-1:0] stage_idx,
  output logic             stage_add,
  output logic             stage_drop
);

  logic [NUM_STAGES-1:0] flags;
  logic                  idx_ok;
  logic                  cur;

  always_comb begin
    idx_ok = (32'(stage_idx) < NUM_STAGES);
    cur    = idx_ok ? flags[stage_idx] : 1'b0;
    stage_add  = stage_req & idx_ok & stage_set & ~cur;
    stage_drop = stage_req & idx_ok & ~stage_set & cur;
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        flags[g] <= 1'b0;
      end else if (stage_req && idx_ok && 32'(stage_idx) == g) begin
        flags[g] <= stage_set;
      end
    end
  end

  AST_DUP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (stage_req && !clear && idx_ok && (flags[stage_idx] == stage_set)) |=> $stable(flags)); // R6

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (stage_req && stage_set && idx_ok && !clear) |=> flags[$past(stage_idx)]); // R5

endmodule

// File: rtl/pid_counter.sv
module pid_counter
  import pid_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             mark_add,
  input  logic             mark_drop,
  input  logic             stage_add,
  input  logic             stage_drop,
  input  logic             preload_en,
  input  logic [CNT_W-1:0] preload_val,
  output logic [CNT_W-1:0] count,
  output logic             active
);

  localparam logic [15:0] MAXV = 16'((64'd1 << CNT_W) - 1);

  logic [1:0]       up;
  logic [1:0]       down;
  logic [15:0]      stepped;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    up      = {1'b0, mark_add} + {1'b0, stage_add};
    down    = {1'b0, mark_drop} + {1'b0, stage_drop};
    stepped = sat_step(16'(count), up, down, MAXV);
    nxt     = preload_en ? preload_val : stepped[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count  <= '0;
      active <= 1'b0;
    end else begin
      count  <= nxt;
      active <= (nxt != '0);
    end
  end

  AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
    active == (count != '0)); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0) && !active); // R1

  AST_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    (preload_en && !clear) |=> count == $past(preload_val)); // R8

endmodule

// File: rtl/pipe_idle_detect.sv
module pipe_idle_detect #(
  parameter int LATENCY    = 4,
  parameter int NUM_STAGES = 4,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             act_pulse,
  input  logic             advance,
  input  logic             stage_req,
  input  logic             stage_set,
  input  logic [IDX_W-1:0] stage_idx,
  input  logic             preload_en,
  input  logic [CNT_W-1:0] preload_val,
  output logic [CNT_W-1:0] count,
  output logic             active
);

  logic mark_add;
  logic mark_drop;
  logic stage_add;
  logic stage_drop;

  pid_history #(.LATENCY(LATENCY)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .act_pulse (act_pulse),
    .advance   (advance),
    .mark_add  (mark_add),
    .mark_drop (mark_drop)
  );

  pid_stage_flags #(.NUM_STAGES(NUM_STAGES), .IDX_W(IDX_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .stage_req  (stage_req),
    .stage_set  (stage_set),
    .stage_idx  (stage_idx),
    .stage_add  (stage_add),
    .stage_drop (stage_drop)
  );

  pid_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .clear       (clear),
    .mark_add    (mark_add),
    .mark_drop   (mark_drop),
    .stage_add   (stage_add),
    .stage_drop  (stage_drop),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .count       (count),
    .active      (active)
  );

endmodule

// File: tb/sim_pipe_idle_detect.sv
module sim_pipe_idle_detect;

  logic       clk = 1'b0;
  logic       rst, clear, act_pulse, advance, stage_req, stage_set, preload_en;
  logic [1:0] stage_idx;
  logic [7:0] preload_val;
  logic [7:0] count;
  logic       active;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  pipe_idle_detect u0 (
    .clk(clk), .rst(rst), .clear(clear), .act_pulse(act_pulse),
    .advance(advance), .stage_req(stage_req), .stage_set(stage_set),
    .stage_idx(stage_idx), .preload_en(preload_en), .preload_val(preload_val),
    .count(count), .active(active)
  );

  // {act, adv, req, set, idx[1:0], pad[1:0], expected count[7:0]}
  localparam int NV = 16;
  localparam logic [15:0] VEC [0:NV-1] = '{
    {1'b1,1'b0,1'b0,1'b0,2'd0,2'd0,8'd1},  // R2 pulse into empty slot 0
    {1'b1,1'b0,1'b0,1'b0,2'd0,2'd0,8'd1},  // R2 pulse into set slot 0
    {1'b1,1'b1,1'b0,1'b0,2'd0,2'd0,8'd2},  // R4 shift then mark
    {1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,8'd2},  // R3
    {1'b0,1'b0,1'b1,1'b1,2'd2,2'd0,8'd3},  // R5 activate 2
    {1'b0,1'b0,1'b1,1'b1,2'd2,2'd0,8'd3},  // R6 duplicate activate
    {1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,8'd3},  // R3
    {1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,8'd2},  // R3 oldest mark leaves
    {1'b1,1'b1,1'b0,1'b0,2'd0,2'd0,8'd2},  // R4 leave and enter together
    {1'b0,1'b0,1'b1,1'b0,2'd1,2'd0,8'd2},  // R6 deactivate inactive 1
    {1'b0,1'b0,1'b1,1'b0,2'd2,2'd0,8'd1},  // R5 deactivate 2
    {1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,8'd1},  // R3
    {1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,8'd1},  // R3
    {1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,8'd1},  // R3
    {1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,8'd0},  // R3 fourth advance drops mark
    {1'b1,1'b0,1'b1,1'b1,2'd0,2'd0,8'd2}   // R5 request with pulse
  };

  task automatic idle_in();
    clear = 0; act_pulse = 0; advance = 0; stage_req = 0; stage_set = 0;
    stage_idx = 0; preload_en = 0; preload_val = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (count !== exp || active !== (exp != 8'd0)) begin
      n_fail++;
      $display("FAIL %s: count=%0d active=%0b expected count=%0d active=%0b",
               req, count, active, exp, (exp != 8'd0));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: cycles=%0d expected <=20000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    idle_in();
    rst = 1;
    tick(); tick();
    rst = 0;
    tick();
    chk("R1 reset", 8'd0);

    for (int i = 0; i < NV; i++) begin
      act_pulse = VEC[i][15];
      advance   = VEC[i][14];
      stage_req = VEC[i][13];
      stage_set = VEC[i][12];
      stage_idx = VEC[i][11:10];
      tick();
      chk($sformatf("R10 vector %0d", i), VEC[i][7:0]);
      idle_in();
    end

    clear = 1; tick(); idle_in();
    chk("R1 clear", 8'd0);
    stage_req = 1; stage_set = 0; stage_idx = 0; tick(); idle_in();
    chk("R1 flag cleared, deactivate ignored", 8'd0);
    for (int k = 0; k < 4; k++) begin
      advance = 1; tick(); idle_in();
    end
    chk("R1 history cleared", 8'd0);
    stage_req = 1; stage_set = 1; stage_idx = 0; tick(); idle_in();
    chk("R1 activate after clear", 8'd1);

    preload_en = 1; preload_val = 8'd200; act_pulse = 1; tick(); idle_in();
    chk("R8 preload wins over pulse", 8'd200);
    preload_en = 1; preload_val = 8'd0; tick(); idle_in();
    chk("R8 preload zero", 8'd0);
    stage_req = 1; stage_set = 0; stage_idx = 0; tick(); idle_in();
    chk("R9 floor at zero", 8'd0);
    preload_en = 1; preload_val = 8'd255; tick(); idle_in();
    stage_req = 1; stage_set = 1; stage_idx = 1; tick(); idle_in();
    chk("R9 ceiling at max", 8'd255);
    clear = 1; preload_en = 1; preload_val = 8'd9; tick(); idle_in();
    chk("R8 clear beats preload", 8'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule